// File: doc/BRIEF.md
# Monochrome Pixel Serialiser

The block turns a stream of 16-bit words into one-bit-per-pixel monochrome video. It reads words from a first-word-fall-through FIFO, where the head word is already on the data lines whenever the FIFO reports ready. It also watches three inputs from a video timer: a pixel-active flag, a line-end strobe and a frame-end strobe.

On each active pixel it emits one bit of the current word, starting with bit 0. That bit drives red, green and blue together, so a 1 is white and a 0 is black. It takes a new word every 16 active pixels. The horizontal active width is expected to be a multiple of 16, so a word never runs across two lines.

After reset the block has not yet synchronised to the frame. Until the first frame-end strobe it ignores the FIFO and shows an alternating magenta/cyan idle colour. After that strobe it streams pixels, and it drives black during blanking.

Top module: `mono_serialiser`

## Requirements
- R1: While reset is asserted, the colour outputs are (red, green, blue) = (0,1,1) and the FIFO read enable is low.
- R2: Until the first frame-end strobe has been taken, every clock shows (1,0,1) or (0,1,1), the colour alternates on every clock, and no word is read from the FIFO, whatever the active flag does.
- R3: The block synchronises on the clock edge that samples the first frame-end strobe. The outputs that edge produces are still idle colour, and pixel streaming starts with the next clock.
- R4: Each word supplies 16 pixels, bit 0 first and bit 15 last, one bit per active clock. Red, green and blue all equal that bit, and they appear on the outputs one clock after the active flag that consumed the bit was sampled.
- R5: The read enable is high for exactly the one clock in which the first pixel of a word is consumed, and only while the FIFO reports ready. The word is taken from the data lines in that same clock.
- R6: After synchronisation, a clock whose active flag is low gives (0,0,0) one clock later and does not advance the bit stream.
- R7: If the FIFO is not ready when a word is due, the block outputs 0 for that whole 16-pixel word slot and does not read.
- R8: A line-end or frame-end strobe resets the position within the word to bit 0. An active pixel in the same clock as the strobe is still output, and the remaining bits of that word are dropped.
- R9: Words are shown in FIFO order, with no bit skipped or repeated, except for the bits dropped under R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| fifo_rdy_i | input | 1 | FIFO holds a word, presented on fifo_data_i |
| fifo_data_i | input | 16 | Head word of the FIFO |
| fifo_pop_o | output | 1 | Read enable: removes the head word |
| pix_active_i | input | 1 | Timer says the current clock is a visible pixel |
| line_end_i | input | 1 | Timer strobe on the last clock of a line |
| frame_end_i | input | 1 | Timer strobe on the last clock of a frame |
| red_o | output | 1 | Red pixel |
| green_o | output | 1 | Green pixel |
| blue_o | output | 1 | Blue pixel |

## Verification
Two functions can land in the same clock: the shifting out of an active pixel, and the realignment of the word position by a line-end strobe. The bench provokes this by raising the line-end strobe together with the eighth active pixel of a word. It then expects that eighth bit on the outputs, expects the last eight bits of the word to be dropped, and expects the next line to open with a fresh read of the following word. The bench also checks synchronisation against the idle pattern, with the FIFO already loaded, and checks a line on which the FIFO is starved.

// File: rtl/mono_pkg.sv
package mono_pkg;

    typedef struct packed {
        logic r;
        logic g;
        logic b;
    } rgb_t;

    localparam rgb_t IDLE_A = '{r: 1'b1, g: 1'b0, b: 1'b1};
    localparam rgb_t IDLE_B = '{r: 1'b0, g: 1'b1, b: 1'b1};
    localparam rgb_t DARK   = '{r: 1'b0, g: 1'b0, b: 1'b0};

    function automatic rgb_t grey(input logic v);
        return '{r: v, g: v, b: v};
    endfunction

endpackage

// File: rtl/mono_idle_gen.sv
module mono_idle_gen
    import mono_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    output rgb_t colour_o
);
    logic phase_d, phase_q;

    always_comb begin
        phase_d = ~phase_q;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) phase_q <= 1'b0;
        else         phase_q <= phase_d;
    end

    assign colour_o = phase_q ? IDLE_B : IDLE_A;

    // R2: the phase flips on every clock out of reset
    p_phase_flip_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (phase_q != $past(phase_q)))
        else $error("idle phase did not toggle");
endmodule

// File: rtl/mono_word_shifter.sv
module mono_word_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              step_i,
    input  logic              realign_i,
    input  logic              fifo_rdy_i,
    input  logic [WORD_W-1:0] fifo_data_i,
    output logic              fifo_pop_o,
    output logic              bit_o
);
    localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-1:0] sr;
        logic [CNT_W-1:0]  cnt;
    } st_t;

    st_t st_d, st_q;
    logic [WORD_W-1:0] word;

    always_comb begin
        st_d       = st_q;
        word       = st_q.sr;
        fifo_pop_o = 1'b0;
        bit_o      = 1'b0;
        if (step_i) begin
            if (st_q.cnt == '0) begin
                word       = fifo_rdy_i ? fifo_data_i : '0;
                fifo_pop_o = fifo_rdy_i;
            end
            bit_o     = word[0];
            st_d.sr   = word >> 1;
            st_d.cnt  = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
        end
        if (realign_i) st_d.cnt = '0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R5: a read only happens when the FIFO offers a word
    p_pop_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fifo_pop_o |-> fifo_rdy_i)
        else $error("read while FIFO not ready");
    // R5: after a read, the position moves to bit 1 unless realigned
    p_pop_then_one_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fifo_pop_o && !realign_i) |=> (st_q.cnt == CNT_W'(1)))
        else $error("read not at start of word");
    // R6: no step and no strobe leaves the position untouched
    p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!step_i && !realign_i) |=> $stable(st_q.cnt))
        else $error("position moved without a pixel");
    // R8: a strobe always returns the position to bit 0
    p_realign_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        realign_i |=> (st_q.cnt == '0))
        else $error("strobe did not realign");
endmodule

// File: rtl/mono_serialiser.sv
module mono_serialiser
    import mono_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              fifo_rdy_i,
    input  logic [WORD_W-1:0] fifo_data_i,
    output logic              fifo_pop_o,
    input  logic              pix_active_i,
    input  logic              line_end_i,
    input  logic              frame_end_i,
    output logic              red_o,
    output logic              green_o,
    output logic              blue_o
);
    typedef struct packed {
        logic synced;
        rgb_t rgb;
    } top_t;

    top_t st_d, st_q;
    rgb_t idle_colour;
    logic pix_bit;
    logic step;
    logic realign;

    assign step    = st_q.synced & pix_active_i;
    assign realign = line_end_i | frame_end_i;

    mono_idle_gen i_idle (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .colour_o (idle_colour)
    );

    mono_word_shifter #(.WORD_W(WORD_W)) i_shift (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .step_i      (step),
        .realign_i   (realign),
        .fifo_rdy_i  (fifo_rdy_i),
        .fifo_data_i (fifo_data_i),
        .fifo_pop_o  (fifo_pop_o),
        .bit_o       (pix_bit)
    );

    always_comb begin
        st_d        = st_q;
        st_d.synced = st_q.synced | frame_end_i;
        if (!st_q.synced)     st_d.rgb = idle_colour;
        else if (pix_active_i) st_d.rgb = grey(pix_bit);
        else                   st_d.rgb = DARK;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '{synced: 1'b0, rgb: IDLE_B};
        else         st_q <= st_d;
    end

    assign red_o   = st_q.rgb.r;
    assign green_o = st_q.rgb.g;
    assign blue_o  = st_q.rgb.b;

    // R2: before sync the colour is one of the two idle patterns
    p_idle_colour_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.synced |-> (blue_o && (red_o != green_o)))
        else $error("bad idle colour");
    // R2: no FIFO reads before sync
    p_no_read_unsynced_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.synced |-> !fifo_pop_o)
        else $error("read before sync");
    // R4: streamed pixels are grey-scale (all channels equal)
    p_mono_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(st_q.synced) && $past(pix_active_i)) |-> (red_o == green_o && green_o == blue_o))
        else $error("channels differ on a pixel");
    // R6: blanking is dark once synced
    p_blank_dark_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(st_q.synced) && !$past(pix_active_i)) |-> (!red_o && !green_o && !blue_o))
        else $error("blanking not dark");
endmodule

// File: tb/test_mono_serialiser.sv
module test_mono_serialiser;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fifo_rdy = 1'b0;
    logic [15:0] fifo_data = '0;
    logic        fifo_pop;
    logic        pix_active = 1'b0;
    logic        line_end = 1'b0;
    logic        frame_end = 1'b0;
    logic        red, green, blue;

    int errors = 0;
    int checks = 0;
    int pops = 0;
    bit starve = 1'b0;
    bit bench_synced = 1'b0;
    bit done = 1'b0;

    logic [15:0] fq[$];
    bit          exp_q[$];

    always #10 clk = ~clk;   // 50 MHz

    mono_serialiser i_mono_serialiser (
        .clk_i(clk), .rst_ni(rst_n),
        .fifo_rdy_i(fifo_rdy), .fifo_data_i(fifo_data), .fifo_pop_o(fifo_pop),
        .pix_active_i(pix_active), .line_end_i(line_end), .frame_end_i(frame_end),
        .red_o(red), .green_o(green), .blue_o(blue)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, expv, $time);
        end
    endtask

    // FIFO model: first word falls through, head removed on read enable
    always @(posedge clk) begin
        if (rst_n && fifo_pop) begin
            pops++;
            if (fq.size() == 0) chk(1'b0, "R5 read of empty FIFO", 1, 0);
            else void'(fq.pop_front());
        end
    end
    always @(negedge clk) begin
        fifo_rdy  <= !starve && (fq.size() > 0);
        fifo_data <= (fq.size() > 0) ? fq[0] : 16'h0;
    end

    // Monitor: pop the scoreboard on each streamed pixel
    bit act_s = 1'b0, syn_s = 1'b0, rst_s = 1'b0;
    bit have_prev = 1'b0;
    logic [2:0] prev_rgb = '0;
    always @(posedge clk) begin
        act_s <= pix_active;
        syn_s <= bench_synced;
        rst_s <= rst_n;
    end
    always @(negedge clk) begin
        if (rst_s && !done) begin
            if (!syn_s) begin
                chk((blue == 1'b1) && (red != green), "R2 idle colour", {red, green, blue}, 3'b101);
                if (have_prev)
                    chk({red, green, blue} != prev_rgb, "R2 idle alternation", {red, green, blue}, ~prev_rgb);
                prev_rgb  = {red, green, blue};
                have_prev = 1'b1;
            end else if (act_s) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected pixel", red, 0);
                end else begin
                    bit e;
                    e = exp_q.pop_front();
                    chk((red == e) && (green == e) && (blue == e), "R4 pixel bit",
                        {red, green, blue}, {e, e, e});
                end
            end else begin
                chk({red, green, blue} == 3'b000, "R6 blanking dark", {red, green, blue}, 0);
            end
        end
    end

    task automatic cyc(input bit a, input bit l, input bit f);
        pix_active = a; line_end = l; frame_end = f;
        @(posedge clk); #2;
        if (f) bench_synced = 1'b1;
        pix_active = 1'b0; line_end = 1'b0; frame_end = 1'b0;
    endtask

    task automatic push_word(input logic [15:0] w, input int nbits);
        fq.push_back(w);
        for (int i = 0; i < nbits; i++) exp_q.push_back(w[i]);
    endtask

    task automatic run_line(input int nact, input int nblank);
        for (int i = 0; i < nact; i++) cyc(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < nblank; i++) cyc(1'b0, i == nblank - 1, 1'b0);
    endtask

    initial begin
        #(20 * 100000);
        chk(1'b0, "watchdog", 0, 1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int pops_before;
        logic [15:0] wa, wb;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk({red, green, blue} == 3'b011, "R1 reset colour", {red, green, blue}, 3'b011);
        chk(fifo_pop == 1'b0, "R1 reset read enable", fifo_pop, 0);
        @(posedge clk); #2;
        rst_n = 1'b1;

        // R2: unsynced with words waiting; active flag toggled
        push_word(16'hA5C3, 16);
        push_word(16'h0F01, 16);
        for (int i = 0; i < 20; i++) cyc(i[0], 1'b0, 1'b0);
        chk(pops == 0, "R2 no read before sync", pops, 0);

        // R3: sync on frame strobe; first line shows the waiting words
        cyc(1'b0, 1'b0, 1'b1);
        run_line(32, 5);
        chk(pops == 2, "R3 R9 two words after sync", pops, 2);

        // R4/R9: random words over a line
        push_word(16'($urandom), 16);
        push_word(16'($urandom), 16);
        run_line(32, 6);
        chk(pops == 4, "R5 one read per word", pops, 4);

        // R7: starved line gives zeros and no read
        starve = 1'b1;
        for (int i = 0; i < 16; i++) exp_q.push_back(1'b0);
        pops_before = pops;
        run_line(16, 4);
        chk(pops == pops_before, "R7 no read while starved", pops, pops_before);
        starve = 1'b0;

        // R8: line strobe with the 8th pixel of a word
        wa = 16'($urandom); wb = 16'($urandom);
        push_word(wa, 8);
        push_word(wb, 16);
        for (int i = 0; i < 7; i++) cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 1'b0);
        chk(fq.size() == 1, "R8 only first word read", fq.size(), 1);
        run_line(0, 4);
        run_line(16, 4);
        chk(pops == 6, "R8 next line reads next word", pops, 6);

        // R8: frame strobe in blanking, then one more line
        cyc(1'b0, 1'b0, 1'b1);
        push_word(16'h8001, 16);
        run_line(16, 3);

        @(negedge clk);
        chk(exp_q.size() == 0, "R9 all bits shown", exp_q.size(), 0);
        chk(fq.size() == 0, "R9 FIFO drained", fq.size(), 0);
        chk(pops == 7, "R5 total reads", pops, 7);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule